// File: doc/BRIEF.md
# Serial Receive Channel with Character FIFO and Node Address Filter

This block is the receive half of a classic asynchronous serial port. A programmable divider turns the core clock into an oversampling tick at sixteen ticks per bit. A deserializer picks each start-bit-framed character off the line and hands it to a small character queue. Software, or a bus bridge, pops characters through a valid/ready read port.

An interrupt line rises once the number of queued characters reaches a selectable trigger depth. A legacy setting shrinks the queue to a single holding slot. For multi-drop buses, a nine-bit setting treats the extra bit after the eight data bits as an address marker. With automatic address recognition on, the receiver stores only the traffic meant for its own node address and silently drops the rest.

Each stored entry carries its data byte, the address marker and a framing-error flag. A queue that is already full when a character completes raises a sticky overrun indication.

Top module: `rx_addr_uart`

## Requirements
- R1: A frame is one low start bit, 8 data bits LSB first, an optional ninth bit, then a high stop bit. Each bit lasts 16*cfg_div clock cycles. A frame sent this way is stored with its data byte unchanged.
- R2: With cfg_fifo_en=1, up to 16 characters are held. They are read out in arrival order, and rd_level reports how many are held.
- R3: irq is high exactly when rd_level is at or above the trigger depth. cfg_trig selects that depth: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters.
- R4: With cfg_fifo_en=0 only one character is held, and irq is high while that one character is present.
- R5: A character that completes while the queue is full is discarded and sets overrun. overrun stays set until ovr_clr is pulsed.
- R6: A stop bit sampled low stores the character with rd_ferr=1. A high stop bit stores it with rd_ferr=0.
- R7: With cfg_nine_bit=1, the bit after the eighth data bit is stored and shown on rd_is_addr. With cfg_nine_bit=0, rd_is_addr is 0.
- R8: With cfg_nine_bit=1 and cfg_auto_addr=1, the node starts deselected. An address character equal to cfg_node_addr selects the node and is stored. Any other address character deselects the node and is dropped. Data characters are stored only while the node is selected.
- R9: rd_ready is high exactly when rd_level is nonzero. rd_data, rd_is_addr and rd_ferr show the oldest entry. A cycle with rd_valid and rd_ready both high removes that entry.
- R10: A low pulse on rxd that ends before the middle of the start bit (tick 8) is not taken as a start bit, and nothing is stored.
- R11: After reset the queue is empty, with rd_ready, irq and overrun all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idles high |
| cfg_div | input | DIV_W | Core cycles per oversampling tick (at least 1) |
| cfg_fifo_en | input | 1 | 1: 16-entry queue, 0: single holding slot |
| cfg_trig | input | 2 | Interrupt trigger depth select |
| cfg_nine_bit | input | 1 | Enables the ninth (address marker) bit |
| cfg_auto_addr | input | 1 | Enables hardware node address filtering |
| cfg_node_addr | input | 8 | This node's address |
| ovr_clr | input | 1 | Pulse that clears the overrun flag |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | A character is available |
| rd_data | output | 8 | Oldest character's data byte |
| rd_is_addr | output | 1 | Oldest character's address marker |
| rd_ferr | output | 1 | Oldest character's framing-error flag |
| rd_level | output | LVL_W | Number of characters held |
| irq | output | 1 | Fill level has reached the trigger depth |
| overrun | output | 1 | Sticky overrun indication |

## Verification
Random data bytes are sent in bursts of random length under each of the four trigger settings. The interrupt is compared after every character, which separates the trigger depths from one another and confirms ordering across pointer wrap.

A run of seventeen frames into the full queue, and two frames into the single holding slot, separates the kept characters from the dropped ones and exercises the sticky overrun flag. A frame with a low stop bit shows whether the error flag is attached to the right entry.

A random mix of matching addresses, foreign addresses and data characters checks the selection state against a bench model. A short low glitch checks that no false start is taken.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef struct packed {
        logic       is_addr;
        logic       ferr;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

endpackage

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (cfg_div <= 1 || st_q.cnt >= cfg_div - 1'b1) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/urx_deser.sv
module urx_deser
    import urx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    input  logic     nine_bit,
    output logic     char_vld,
    output rx_char_t char_out
);

    typedef struct packed {
        rx_state_e st;
        logic [1:0] sync;
        logic [3:0] tcnt;
        logic [3:0] bcnt;
        logic [8:0] shreg;
        logic       vld;
        rx_char_t   chr;
    } ds_state_t;

    ds_state_t st_d, st_q;
    logic      rx_s;
    logic [3:0] last_bit;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.sync = {st_q.sync[0], rxd};
        rx_s      = st_q.sync[1];
        last_bit  = nine_bit ? 4'd8 : 4'd7;
        if (tick) begin
            case (st_q.st)
                ST_IDLE: begin
                    if (!rx_s) begin
                        st_d.st   = ST_START;
                        st_d.tcnt = '0;
                    end
                end
                ST_START: begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                    if (st_q.tcnt == 4'd7) begin
                        if (!rx_s) begin
                            st_d.st   = ST_DATA;
                            st_d.tcnt = '0;
                            st_d.bcnt = '0;
                        end else begin
                            st_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                    if (st_q.tcnt == 4'd15) begin
                        st_d.shreg[st_q.bcnt] = rx_s;
                        st_d.bcnt             = st_q.bcnt + 1'b1;
                        if (st_q.bcnt == last_bit) st_d.st = ST_STOP;
                    end
                end
                ST_STOP: begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                    if (st_q.tcnt == 4'd15) begin
                        st_d.vld          = 1'b1;
                        st_d.chr.data     = st_q.shreg[7:0];
                        st_d.chr.is_addr  = nine_bit & st_q.shreg[8];
                        st_d.chr.ferr     = ~rx_s;
                        st_d.st           = ST_IDLE;
                    end
                end
                default: st_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.st   <= ST_IDLE;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign char_vld = st_q.vld;
    assign char_out = st_q.chr;

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             wr_drop
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wptr;
        logic [PTR_W-1:0]        rptr;
        logic [LVL_W-1:0]        level;
    } ff_state_t;

    ff_state_t        st_d, st_q;
    logic [LVL_W-1:0] cap;
    logic             full, do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        cap   = bypass ? LVL_W'(1) : LVL_W'(DEPTH);
        full  = st_q.level >= cap;
        do_wr = wr_en & ~full;
        do_rd = rd_en & (st_q.level != '0);
        if (do_wr) begin
            st_d.mem[st_q.wptr] = wr_data;
            st_d.wptr = (st_q.wptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_rd) begin
            st_d.rptr = (st_q.rptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        st_d.level = st_q.level + LVL_W'(do_wr) - LVL_W'(do_rd);
        wr_drop    = wr_en & full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rptr];
    assign level = st_q.level;

endmodule

// File: rtl/rx_addr_uart.sv
module rx_addr_uart
    import urx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_fifo_en,
    input  logic [1:0]       cfg_trig,
    input  logic             cfg_nine_bit,
    input  logic             cfg_auto_addr,
    input  logic [7:0]       cfg_node_addr,
    input  logic             ovr_clr,
    input  logic             rd_valid,
    output logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             rd_is_addr,
    output logic             rd_ferr,
    output logic [LVL_W-1:0] rd_level,
    output logic             irq,
    output logic             overrun
);

    typedef struct packed {
        logic selected;
        logic ovr;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic             tick, char_vld, store, wr_drop, filt_on;
    rx_char_t         char_in, head;
    logic [LVL_W-1:0] level, trig_lvl;
    logic [CHAR_W-1:0] head_bits;

    urx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .tick(tick)
    );

    urx_deser u_deser (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .nine_bit(cfg_nine_bit), .char_vld(char_vld), .char_out(char_in)
    );

    urx_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .bypass(~cfg_fifo_en),
        .wr_en(store), .wr_data(char_in), .rd_en(rd_valid),
        .head(head_bits), .level(level), .wr_drop(wr_drop)
    );

    always_comb begin
        st_d    = st_q;
        filt_on = cfg_nine_bit & cfg_auto_addr;
        store   = char_vld;
        if (char_vld && filt_on) begin
            if (char_in.is_addr) begin
                st_d.selected = (char_in.data == cfg_node_addr);
                store         = (char_in.data == cfg_node_addr);
            end else begin
                store = st_q.selected;
            end
        end
        st_d.ovr = (st_q.ovr & ~ovr_clr) | wr_drop;
        case (cfg_trig)
            2'd0:    trig_lvl = LVL_W'(1);
            2'd1:    trig_lvl = LVL_W'(DEPTH / 4);
            2'd2:    trig_lvl = LVL_W'(DEPTH / 2);
            default: trig_lvl = LVL_W'(DEPTH - 2);
        endcase
        if (!cfg_fifo_en) trig_lvl = LVL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head       = rx_char_t'(head_bits);
    assign rd_ready   = (level != '0);
    assign rd_data    = head.data;
    assign rd_is_addr = head.is_addr;
    assign rd_ferr    = head.ferr;
    assign rd_level   = level;
    assign irq        = (level >= trig_lvl);
    assign overrun    = st_q.ovr;

endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_fifo_en,
    input logic             ovr_clr,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [LVL_W-1:0] rd_level,
    input logic             irq,
    input logic             overrun
);

    // R2
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level <= LVL_W'(DEPTH));

    // R4
    bypass_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fifo_en |-> rd_level <= LVL_W'(1));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);

    // R9
    ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready == (rd_level != '0));

    // R9
    pop_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> rd_level <= $past(rd_level));

    // R3
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_level != '0);

endmodule

bind rx_addr_uart urx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .ovr_clr(ovr_clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_level(rd_level),
    .irq(irq), .overrun(overrun)
);

// File: tb/tb_rx_addr_uart.sv
module tb_rx_addr_uart;

    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int DIV   = 2;
    localparam int BITC  = 16 * DIV;

    logic clk = 0, rst_n = 0, rxd = 1;
    logic [15:0] cfg_div = 16'(DIV);
    logic cfg_fifo_en = 1, cfg_nine_bit = 0, cfg_auto_addr = 0;
    logic [1:0] cfg_trig = 0;
    logic [7:0] cfg_node_addr = 8'h5A;
    logic ovr_clr = 0, rd_valid = 0;
    logic rd_ready, rd_is_addr, rd_ferr, irq, overrun;
    logic [7:0] rd_data;
    logic [LVL_W-1:0] rd_level;

    int tests = 0, fails = 0;
    logic [9:0] exp_q[$];
    bit exp_ovr = 0, sel = 0;

    always #5 clk = ~clk;

    rx_addr_uart dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_div(cfg_div),
        .cfg_fifo_en(cfg_fifo_en), .cfg_trig(cfg_trig), .cfg_nine_bit(cfg_nine_bit),
        .cfg_auto_addr(cfg_auto_addr), .cfg_node_addr(cfg_node_addr), .ovr_clr(ovr_clr),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_is_addr(rd_is_addr),
        .rd_ferr(rd_ferr), .rd_level(rd_level), .irq(irq), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int trig_depth(input logic [1:0] t, input logic fen);
        if (!fen) return 1;
        case (t)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame and updates the bench model (R1, R5, R6, R7, R8)
    task automatic send_frame(input logic [7:0] d, input logic a, input logic good_stop);
        logic keep;
        rxd = 0; wait_cyc(BITC);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_cyc(BITC); end
        if (cfg_nine_bit) begin rxd = a; wait_cyc(BITC); end
        rxd = good_stop; wait_cyc(BITC);
        rxd = 1; wait_cyc(BITC);
        keep = 1;
        if (cfg_nine_bit && cfg_auto_addr) begin
            if (a) begin sel = (d == cfg_node_addr); keep = sel; end
            else keep = sel;
        end
        if (keep) begin
            if (exp_q.size() >= (cfg_fifo_en ? DEPTH : 1)) exp_ovr = 1;
            else exp_q.push_back({cfg_nine_bit & a, ~good_stop, d});
        end
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            logic [9:0] e;
            e = exp_q.pop_front();
            check({req, " ready"}, rd_ready, 1);
            check({req, " entry"}, {rd_is_addr, rd_ferr, rd_data}, e);
            rd_valid = 1; @(negedge clk); rd_valid = 0;
        end
        check({req, " R9 empty after drain"}, rd_ready, 0);
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        wait_cyc(4); rst_n = 1; wait_cyc(2);
        // R11 reset state
        check("R11 ready", rd_ready, 0);
        check("R11 irq", irq, 0);
        check("R11 overrun", overrun, 0);
        check("R11 level", rd_level, 0);

        // R1 R2 R3 R9: random bursts under each trigger
        for (int t = 0; t < 4; t++) begin
            int n;
            cfg_trig = 2'(t);
            n = $urandom_range(15, 1);
            for (int k = 0; k < n; k++) begin
                send_frame(8'($urandom), 0, 1);
                check("R2 level", rd_level, exp_q.size());
                check("R3 irq", irq, int'(exp_q.size() >= trig_depth(cfg_trig, 1)));
            end
            drain("R1 R2");
        end

        // R5: overrun on a full queue
        cfg_trig = 3;
        for (int k = 0; k < 17; k++) send_frame(8'($urandom), 0, 1);
        check("R5 level full", rd_level, 16);
        check("R5 overrun set", overrun, int'(exp_ovr));
        check("R3 irq at 16", irq, 1);
        drain("R5");
        check("R5 overrun sticky", overrun, 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0; exp_ovr = 0;
        check("R5 overrun cleared", overrun, 0);

        // R4: single holding slot
        cfg_fifo_en = 0;
        send_frame(8'hA5, 0, 1);
        check("R4 irq one char", irq, 1);
        send_frame(8'h3C, 0, 1);
        check("R4 level", rd_level, 1);
        check("R4 overrun", overrun, 1);
        drain("R4");
        ovr_clr = 1; @(negedge clk); ovr_clr = 0; exp_ovr = 0;
        cfg_fifo_en = 1;

        // R6: framing error flag stored with its character
        send_frame(8'h81, 0, 0);
        send_frame(8'h7E, 0, 1);
        check("R6 ferr", rd_ferr, 1);
        drain("R6");

        // R10: short glitch
        rxd = 0; wait_cyc(3 * DIV); rxd = 1; wait_cyc(12 * BITC);
        check("R10 no store", rd_level, 0);
        check("R10 no overrun", overrun, 0);

        // R7: nine-bit marker without filtering
        cfg_nine_bit = 1;
        send_frame(8'h11, 1, 1);
        send_frame(8'h22, 0, 1);
        check("R7 marker", rd_is_addr, 1);
        drain("R7");

        // R8: address filtering, directed then random
        cfg_auto_addr = 1;
        send_frame(8'h01, 0, 1);
        check("R8 dropped unselected", rd_level, 0);
        send_frame(8'h33, 1, 1);
        check("R8 foreign address dropped", rd_level, 0);
        send_frame(8'h5A, 1, 1);
        send_frame(8'h44, 0, 1);
        check("R8 selected stores", rd_level, 2);
        send_frame(8'h66, 1, 1);
        send_frame(8'h77, 0, 1);
        check("R8 deselected", rd_level, 2);
        drain("R8");
        for (int k = 0; k < 14; k++) begin
            logic a;
            logic [7:0] d;
            a = 1'($urandom);
            d = ($urandom_range(1, 0) == 0) ? 8'h5A : 8'($urandom);
            send_frame(d, a, 1);
            check("R8 random level", rd_level, exp_q.size());
        end
        drain("R8 random");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule